// File: doc/BRIEF.md
# Nibble-Serial Field ALU

This unit applies one arithmetic or shift operation to a chosen field of a 64-bit word. It works on a single 4-bit digit per clock. It starts at the lowest digit of the field and moves upward, so a field of n nibbles takes n cycles. A start strobe loads both source words along with the operation, the field code, a digit pointer and a decimal/hex flag. From then on the unit works alone and pulses done when the last digit of the field has been written.

Nibbles outside the field are copied from the first source unchanged. In decimal mode every digit is treated as BCD and corrected on the fly. A carry flag keeps the carry or borrow out of the top digit of the last arithmetic operation. A sticky flag records any nonzero digit lost by a right shift and holds until a clear strobe removes it.

Top module: `nib_field_alu`

## Requirements
- R1: After reset, result is zero and carry, sticky and done are all low.
- R2: The field code selects the nibble range lo..hi: 0 = 0..15, 1 = 0..4, 2 = 0..2, 3 = 2..2, 4 = 0..1, 5 = 3..14, 6 = 15..15. Codes 9 to 15 behave as code 0.
- R3: Field code 7 selects only nibble ptr. Field code 8 selects nibbles 0..ptr.
- R4: Every nibble of result outside the selected field equals the same nibble of src_a.
- R5: When start is accepted at a clock edge, done is high for exactly one cycle, n cycles later, where n is the field width in nibbles. From then on, result holds the final value and stays stable while idle.
- R6: Op codes 0 (add a+b), 1 (subtract a-b), 2 (increment a+1) and 3 (decrement a-1) are performed digit by digit from lo to hi, with the carry or borrow rippling upward. In hex mode (dec_mode=0) each digit is 4-bit binary, and carry is set to the carry or borrow out of nibble hi.
- R7: With dec_mode=1, a digit sum above 9 is replaced by the sum plus 6 (mod 16) and carries 1. A digit difference below 0 is replaced by the difference minus 6 (mod 16) and borrows 1.
- R8: Op code 4, and the unused code 7, write zero to every field nibble. Ops 4 to 7 leave carry unchanged.
- R9: Op 5 moves each field nibble up one place and puts 0 into nibble lo. Op 6 moves each field nibble down one place and puts 0 into nibble hi.
- R10: Op 6 sets sticky when the original nibble lo is nonzero. Sticky then stays high until sticky_clr is high at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R11: A start pulse while an operation is in progress is ignored. It does not change the running result, carry or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code |
| fld | input | 4 | Field code |
| ptr | input | 4 | Digit pointer for fields 7 and 8 |
| dec_mode | input | 1 | 1 = BCD digits, 0 = binary digits |
| src_a | input | 64 | First operand; also source of untouched nibbles |
| src_b | input | 64 | Second operand for add and subtract |
| sticky_clr | input | 1 | Clear the sticky flag |
| result | output | 64 | Result word |
| carry | output | 1 | Carry/borrow out of the last arithmetic field |
| sticky | output | 1 | Nonzero digit lost by a right shift |
| done | output | 1 | One-cycle pulse when the result is complete |

## Verification
The hardest case to reach is a sticky set and a sticky clear landing on the same clock edge. The set happens on the first processing edge of a right shift, one edge after start is taken, so the bench raises sticky_clr for exactly that one cycle. The second hard case is a start pulse that arrives in the middle of a long whole-word operation. The bench sends a second start with different operands a few cycles into a 16-nibble run and checks that both the timing and the result belong to the first request. BCD corner cases (9 + 1 rippling through a whole field, 0 - 1 borrowing through it) are driven directly. Random operations with valid BCD digits cover the remaining combinations.

// File: rtl/nib_field_alu.sv
module nib_field_alu #(
  parameter int NIBBLES = 16,
  parameter int PW = $clog2(NIBBLES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           op,
  input  logic [3:0]           fld,
  input  logic [PW-1:0]        ptr,
  input  logic                 dec_mode,
  input  logic [4*NIBBLES-1:0] src_a,
  input  logic [4*NIBBLES-1:0] src_b,
  input  logic                 sticky_clr,
  output logic [4*NIBBLES-1:0] result,
  output logic                 carry,
  output logic                 sticky,
  output logic                 done
);
  localparam int DW = 4 * NIBBLES;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_INC = 3'd2, OP_DEC = 3'd3;
  localparam logic [2:0] OP_CLR = 3'd4, OP_SHL = 3'd5, OP_SHR = 3'd6;

  logic          busy, dec_r, cy, cout;
  logic [2:0]    op_r;
  logic [PW-1:0] idx, lo_r, hi_r, f_lo, f_hi, idx_n;
  logic [DW-1:0] opb;
  logic [3:0]    x, y, xn, ya, nib, prev;
  logic [4:0]    sum5, dif5;

  always_comb begin
    f_lo = '0;
    f_hi = PW'(NIBBLES - 1);
    case (fld)
      4'd1: f_hi = PW'(4);
      4'd2: f_hi = PW'(2);
      4'd3: begin f_lo = PW'(2); f_hi = PW'(2); end
      4'd4: f_hi = PW'(1);
      4'd5: begin f_lo = PW'(3); f_hi = PW'(NIBBLES - 2); end
      4'd6: f_lo = PW'(NIBBLES - 1);
      4'd7: begin f_lo = ptr; f_hi = ptr; end
      4'd8: f_hi = ptr;
      default: ;
    endcase
  end

  assign idx_n = idx + 1'b1;
  assign x     = result[{idx, 2'b00} +: 4];
  assign xn    = result[{idx_n, 2'b00} +: 4];
  assign y     = opb[{idx, 2'b00} +: 4];
  assign ya    = (op_r == OP_ADD || op_r == OP_SUB) ? y : 4'd0;
  assign sum5  = {1'b0, x} + {1'b0, ya} + {4'd0, cy};
  assign dif5  = {1'b0, x} - {1'b0, ya} - {4'd0, cy};

  always_comb begin
    nib  = 4'd0;
    cout = 1'b0;
    case (op_r)
      OP_ADD, OP_INC: begin
        if (dec_r && sum5 > 5'd9) begin
          nib  = sum5[3:0] + 4'd6;
          cout = 1'b1;
        end else begin
          nib  = sum5[3:0];
          cout = sum5[4];
        end
      end
      OP_SUB, OP_DEC: begin
        nib  = (dec_r && dif5[4]) ? dif5[3:0] - 4'd6 : dif5[3:0];
        cout = dif5[4];
      end
      OP_SHL: nib = prev;
      OP_SHR: nib = (idx == hi_r) ? 4'd0 : xn;
      default: nib = 4'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      opb    <= '0;
      idx    <= '0;
      lo_r   <= '0;
      hi_r   <= '0;
      op_r   <= OP_CLR;
      dec_r  <= 1'b0;
      cy     <= 1'b0;
      prev   <= 4'd0;
      carry  <= 1'b0;
      sticky <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sticky_clr) sticky <= 1'b0;
      if (!busy && start) begin
        busy   <= 1'b1;
        result <= src_a;
        opb    <= src_b;
        idx    <= f_lo;
        lo_r   <= f_lo;
        hi_r   <= f_hi;
        op_r   <= op;
        dec_r  <= dec_mode;
        cy     <= (op == OP_INC || op == OP_DEC);
        prev   <= 4'd0;
      end else if (busy) begin
        result[{idx, 2'b00} +: 4] <= nib;
        cy   <= cout;
        prev <= x;
        if (op_r == OP_SHR && idx == lo_r && x != 4'd0) sticky <= 1'b1;
        if (idx == hi_r) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (op_r <= OP_DEC) carry <= cout;
        end else begin
          idx <= idx_n;
        end
      end
    end
  end
endmodule

// File: rtl/nib_field_alu_chk.sv
module nib_field_alu_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          sticky_clr,
  input logic          busy,
  input logic          done,
  input logic          carry,
  input logic          sticky,
  input logic [DW-1:0] result
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

  // R8
  carry_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(carry) |-> done);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !sticky_clr) |=> sticky);

  // R10
  sticky_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky) |-> $past(busy));

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind nib_field_alu nib_field_alu_chk #(.DW(4 * NIBBLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sticky_clr(sticky_clr),
  .busy(busy), .done(done), .carry(carry), .sticky(sticky), .result(result)
);

// File: tb/test_nib_field_alu.sv
module test_nib_field_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [3:0]  fld_i = 4'd0;
  logic [3:0]  ptr_i = 4'd0;
  logic        dec_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        sclr = 1'b0;
  logic [63:0] result;
  logic        carry, sticky, done;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  nib_field_alu i_nib_field_alu (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .fld(fld_i),
    .ptr(ptr_i), .dec_mode(dec_i), .src_a(a_i), .src_b(b_i),
    .sticky_clr(sclr), .result(result), .carry(carry), .sticky(sticky),
    .done(done)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic void fld_range(input logic [3:0] f, input logic [3:0] p,
                                    output int lo, output int hi);
    lo = 0; hi = 15;
    case (f)
      4'd1: hi = 4;
      4'd2: hi = 2;
      4'd3: begin lo = 2; hi = 2; end
      4'd4: hi = 1;
      4'd5: begin lo = 3; hi = 14; end
      4'd6: lo = 15;
      4'd7: begin lo = int'(p); hi = int'(p); end
      4'd8: hi = int'(p);
      default: ;
    endcase
  endfunction

  function automatic void ref_op(input logic [2:0] o, input logic [3:0] f, input logic [3:0] p,
                                 input logic d, input logic [63:0] a, input logic [63:0] b,
                                 output logic [63:0] r, output logic c, output logic s,
                                 output int n);
    int lo, hi, x, y, t, cc;
    fld_range(f, p, lo, hi);
    n  = hi - lo + 1;
    r  = a;
    s  = 1'b0;
    cc = (o == 3'd2 || o == 3'd3) ? 1 : 0;
    for (int i = lo; i <= hi; i++) begin
      x = int'(a[4*i +: 4]);
      y = (o == 3'd0 || o == 3'd1) ? int'(b[4*i +: 4]) : 0;
      case (o)
        3'd0, 3'd2: begin
          t = x + y + cc;
          if (d && t > 9) begin r[4*i +: 4] = 4'((t + 6) % 16); cc = 1; end
          else begin r[4*i +: 4] = 4'(t % 16); cc = (t > 15) ? 1 : 0; end
        end
        3'd1, 3'd3: begin
          t = x - y - cc;
          if (t < 0) begin
            r[4*i +: 4] = d ? 4'((t + 26) % 16) : 4'((t + 16) % 16);
            cc = 1;
          end else begin
            r[4*i +: 4] = 4'(t);
            cc = 0;
          end
        end
        3'd5: r[4*i +: 4] = (i == lo) ? 4'd0 : a[4*(i-1) +: 4];
        3'd6: r[4*i +: 4] = (i == hi) ? 4'd0 : a[4*(i+1) +: 4];
        default: r[4*i +: 4] = 4'd0;
      endcase
    end
    c = (cc != 0);
    if (o == 3'd6 && a[4*lo +: 4] != 4'd0) s = 1'b1;
  endfunction

  // cycle-level reference model
  logic        m_busy, m_done, m_carry, m_sticky, m_pend, m_arith, m_nc;
  logic [63:0] m_res, m_nres;
  int          m_left;
  logic [63:0] t_r;
  logic        t_c, t_s;
  int          t_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_carry <= 0; m_sticky <= 0; m_pend <= 0;
      m_arith <= 0; m_nc <= 0; m_res <= '0; m_nres <= '0; m_left <= 0;
    end else begin
      m_done <= 1'b0;
      if (sclr) m_sticky <= 1'b0;
      if (!m_busy && start) begin
        ref_op(op_i, fld_i, ptr_i, dec_i, a_i, b_i, t_r, t_c, t_s, t_n);
        m_busy  <= 1'b1;
        m_left  <= t_n;
        m_pend  <= t_s;
        m_nres  <= t_r;
        m_nc    <= t_c;
        m_arith <= (op_i < 3'd4);
      end else if (m_busy) begin
        if (m_pend) m_sticky <= 1'b1;
        m_pend <= 1'b0;
        if (m_left == 1) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
          m_res  <= m_nres;
          if (m_arith) m_carry <= m_nc;
        end else begin
          m_left <= m_left - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("done vs model", {63'd0, done}, {63'd0, m_done});
      chk("carry vs model", {63'd0, carry}, {63'd0, m_carry});
      chk("sticky vs model", {63'd0, sticky}, {63'd0, m_sticky});
      if (!m_busy) chk("result vs model", result, m_res);
    end
  end

  task automatic run_op(input logic [2:0] o, input logic [3:0] f, input logic [3:0] p,
                        input logic d, input logic [63:0] a, input logic [63:0] b,
                        output int lat);
    @(negedge clk);
    op_i = o; fld_i = f; ptr_i = p; dec_i = d; a_i = a; b_i = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic [63:0] bcdify(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 16; i++) r[4*i +: 4] = 4'(int'(v[4*i +: 4]) % 10);
    return r;
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    int lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 reset result", result, 64'd0);
    chk("R1 reset flags", {61'd0, carry, sticky, done}, 64'd0);

    cur_req = "R6";
    run_op(3'd0, 4'd0, 4'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, lat);
    chk("R6 hex add W wrap", result, 64'd0);
    chk("R6 carry out", {63'd0, carry}, 64'd1);
    chk("R5 latency W", 64'(lat), 64'd16);
    @(negedge clk);
    chk("R5 done single pulse", {63'd0, done}, 64'd0);
    run_op(3'd3, 4'd4, 4'd0, 1'b0, 64'hAAAA_AAAA_AAAA_AA00, 64'd0, lat);
    chk("R6 hex dec B borrow", result, 64'hAAAA_AAAA_AAAA_AAFF);
    chk("R6 borrow flag", {63'd0, carry}, 64'd1);
    chk("R5 latency B", 64'(lat), 64'd2);
    cur_req = "R2";
    run_op(3'd2, 4'd3, 4'd0, 1'b0, 64'h1234_5678_9ABC_DF21, 64'd0, lat);
    chk("R2 inc XS", result, 64'h1234_5678_9ABC_D021);
    chk("R5 latency XS", 64'(lat), 64'd1);

    cur_req = "R7";
    run_op(3'd0, 4'd1, 4'd0, 1'b1, 64'h1234_5678_9AB9_9999, 64'd1, lat);
    chk("R7 bcd add A ripple", result, 64'h1234_5678_9AB0_0000);
    chk("R7 bcd carry", {63'd0, carry}, 64'd1);
    chk("R5 latency A", 64'(lat), 64'd5);
    run_op(3'd1, 4'd2, 4'd0, 1'b1, 64'd0, 64'd1, lat);
    chk("R7 bcd sub X borrow", result, 64'h0000_0000_0000_0999);
    run_op(3'd0, 4'd0, 4'd0, 1'b1, 64'h0000_0000_0000_0458, 64'h0000_0000_0000_0367, lat);
    chk("R7 bcd add W no carry", result, 64'h0000_0000_0000_0825);
    chk("R7 bcd carry clear", {63'd0, carry}, 64'd0);

    cur_req = "R3";
    run_op(3'd0, 4'd7, 4'd7, 1'b0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, lat);
    chk("R3 P field ptr 7", result, 64'h0000_0000_F000_0000);
    chk("R5 latency P", 64'(lat), 64'd1);
    run_op(3'd0, 4'd0, 4'd0, 1'b0, 64'hF000_0000_0000_0000, 64'hF000_0000_0000_0000, lat);
    cur_req = "R8";
    run_op(3'd4, 4'd8, 4'd5, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, lat);
    chk("R3 WP clear ptr 5", result, 64'hFFFF_FFFF_FF00_0000);
    chk("R8 carry kept by clear", {63'd0, carry}, 64'd1);
    chk("R5 latency WP", 64'(lat), 64'd6);
    run_op(3'd4, 4'd5, 4'd0, 1'b0, 64'h1234_5678_9ABC_DEF1, 64'd0, lat);
    chk("R8 clear M, R4 outside kept", result, 64'h1000_0000_0000_0EF1);

    cur_req = "R9";
    run_op(3'd5, 4'd0, 4'd0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'd0, lat);
    chk("R9 shl W", result, 64'h1234_5678_9ABC_DEF0);
    chk("R10 no sticky from left shift", {63'd0, sticky}, 64'd0);
    run_op(3'd6, 4'd5, 4'd0, 1'b0, 64'hF123_4567_89AB_CDEF, 64'd0, lat);
    chk("R9 shr M", result, 64'hF012_3456_789A_BDEF);
    cur_req = "R10";
    chk("R10 sticky set", {63'd0, sticky}, 64'd1);
    run_op(3'd6, 4'd6, 4'd0, 1'b0, 64'h0FFF_FFFF_FFFF_FFFF, 64'd0, lat);
    chk("R10 sticky held", {63'd0, sticky}, 64'd1);
    @(negedge clk); sclr = 1'b1;
    @(negedge clk); sclr = 1'b0;
    chk("R10 sticky cleared", {63'd0, sticky}, 64'd0);
    @(negedge clk);
    op_i = 3'd6; fld_i = 4'd4; ptr_i = 4'd0; dec_i = 1'b0;
    a_i = 64'h0000_0000_0000_0035; b_i = 64'd0; start = 1'b1;
    @(negedge clk); start = 1'b0; sclr = 1'b1;
    @(negedge clk); sclr = 1'b0;
    while (!done) @(negedge clk);
    chk("R10 set beats clear", {63'd0, sticky}, 64'd1);
    chk("R9 shr B", result, 64'h0000_0000_0000_0003);

    cur_req = "R11";
    @(negedge clk);
    op_i = 3'd0; fld_i = 4'd0; dec_i = 1'b0;
    a_i = 64'h1111_1111_1111_1111; b_i = 64'h2222_2222_2222_2222; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    op_i = 3'd4; fld_i = 4'd6; a_i = 64'hDEAD_BEEF_0000_0000; b_i = 64'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 3;
    while (!done) begin @(negedge clk); lat++; end
    chk("R11 running op kept", result, 64'h3333_3333_3333_3333);
    chk("R11 timing kept", 64'(lat), 64'd16);

    cur_req = "R2";
    for (int f = 0; f < 16; f++) begin
      run_op(3'd0, 4'(f), 4'd9, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, lat);
      fld_range(4'(f), 4'd9, lo, hi);
      chk("R2 field width", 64'(lat), 64'(hi - lo + 1));
    end

    cur_req = "R4";
    for (int k = 0; k < 250; k++) begin
      logic [63:0] ra, rb;
      logic        rd;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rd = 1'($urandom_range(0, 1));
      if (rd) begin ra = bcdify(ra); rb = bcdify(rb); end
      if ($urandom_range(0, 7) == 0) sclr = 1'b1;
      run_op(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
             4'($urandom_range(0, 15)), rd, ra, rb, lat);
      sclr = 1'b0;
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule